// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits between an on-chip read port and the pins of a serial flash device. When it owns the pins, each read request that arrives on the port becomes one complete flash read sequence. The sequence sends an opcode, then a chosen number of address bytes, then a run of dummy clocks, and then captures four data bytes. It returns those bytes as one 32-bit word. The shape of the sequence comes from a packed setup register that can be written at run time. The data phase can be single-line or four lines wide.

A one-bit switch register decides who drives the flash pins. When the bit is set, this translator owns them. When the bit is clear, a separate command-driven engine owns them, and this block refuses reads with an error response. It starts no flash cycle in that case.

The serial clock runs at half the system clock. It idles low and follows SPI mode 0. The opcode and address always travel on the single output line.

Top module: `sflash_mmap_reader`

## Requirements
- R1: The read opcode comes from setup bits 7:0 (reset value 0x03). It is the first byte of every sequence, sent most significant bit first on `mosi`.
- R2: Setup bits 9:8 hold an address code n, and n+1 address bytes follow the opcode. These are the low n+1 bytes of `rdAddr`, sent most significant byte and bit first. For example, code 2 sends three bytes.
- R3: Between the address and the data, the block issues 8×(setup bits 11:10) + (setup bits 28:24) dummy clocks. Setup bits 23:16 have no effect on a read.
- R4: Read type value 3 in setup bits 13:12 selects quad data. Each clock then samples `sdIn[3:0]`, with `sdIn[3]` as the most significant bit, and the high nibble of each byte comes first (8 clocks in all). Any other value samples only `sdIn[1]`, most significant bit first (32 clocks in all).
- R5: The four received bytes form a little-endian word. The first byte received lands in `rdData[7:0]` and the last in `rdData[31:24]`.
- R6: `cfgSel` picks the register for a configuration write: 0 is setup and 1 is switch. Switch bit 0 drives `pinsOwned`. While `pinsOwned` is low, `csN` stays high.
- R7: A read request while the switch bit is clear is answered on the next cycle with `rdValid` and `rdErr` both high. `csN` stays high and `sclk` stays low throughout.
- R8: A read that completes raises `csN` in the same cycle as a one-cycle `rdValid` pulse, with `rdErr` low.
- R9: `sclk` is low whenever `csN` is high. Each serial clock lasts two system cycles: one low and one high. `mosi` changes only while `sclk` is low.
- R10: After reset, `csN` is high, `sclk` is low, `pinsOwned` is low and `rdValid` is low. The setup register then holds a single-line read: opcode 0x03, three address bytes and no dummy clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Configuration write target: 0 is setup, 1 is switch |
| cfgWrData | input | 32 | Configuration write data |
| rdReq | input | 1 | One-cycle read request, taken only while no read is in progress |
| rdAddr | input | ADDR_W | Flash byte address of the read |
| rdValid | output | 1 | One-cycle read response strobe |
| rdErr | output | 1 | Response is an error because the pins are not owned |
| rdData | output | 8*DATA_BYTES | Little-endian read word |
| pinsOwned | output | 1 | Flash pins belong to this translator |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output line for opcode and address |
| sdIn | input | 4 | Flash data lines; line 1 carries single-line data |

## Verification
Several rules are checked by assertions on every cycle. Chip select stays high while the pins are not owned. The serial clock is idle and does not hold high for more than one cycle. The output line is stable during the high phase. Chip select rises only together with a successful response pulse. An error response never comes with an active chip select.

Other behaviour can only be shown by the bench's directed scenarios with a flash model. These include the bit-exact content of the opcode and address, the number of dummy clocks for each setup code, and the lane and nibble order of quad capture. They also include the little-endian packing of the word and the fact that the write opcode field has no effect.

// File: rtl/sflash_mmap_pkg.sv
package sflash_mmap_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_DONE, S_ERR
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture address and opcode into the transmit shifter
    logic txShift;  // advance transmit shifter
    logic rxShift;  // capture one data beat
    logic drive;    // put transmit shifter on mosi
    logic respond;  // present response
    logic err;      // response is an error
  } seqStrobe_t;

  // Decoded read sequence shape from datapath to control
  typedef struct packed {
    logic [2:0] addrBytes;
    logic [5:0] dummyClks;
    logic       quad;
  } readShape_t;

endpackage

// File: rtl/sflash_mmap_ctrl.sv
module sflash_mmap_ctrl
  import sflash_mmap_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       owned,
  input  readShape_t shape,
  output seqStrobe_t stb,
  output logic       csN,
  output logic       sclk
);

  localparam int CNT_W = $clog2(8 * DATA_BYTES + 64);

  seqState_t state, stateNext;
  logic phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] phaseLen;
  logic active, bitEnd;

  assign active = (state == S_CMD) || (state == S_ADDR) ||
                  (state == S_DUMMY) || (state == S_DATA);

  always_comb begin
    case (state)
      S_CMD:   phaseLen = CNT_W'(8);
      S_ADDR:  phaseLen = CNT_W'({shape.addrBytes, 3'b000});
      S_DUMMY: phaseLen = CNT_W'(shape.dummyClks);
      S_DATA:  phaseLen = shape.quad ? CNT_W'(2 * DATA_BYTES) : CNT_W'(8 * DATA_BYTES);
      default: phaseLen = CNT_W'(1);
    endcase
  end

  assign bitEnd = phase && (bitCnt == phaseLen - CNT_W'(1));

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (rdReq) stateNext = owned ? S_CMD : S_ERR;
      S_CMD:   if (bitEnd) stateNext = S_ADDR;
      S_ADDR:  if (bitEnd) stateNext = (shape.dummyClks == '0) ? S_DATA : S_DUMMY;
      S_DUMMY: if (bitEnd) stateNext = S_DATA;
      S_DATA:  if (bitEnd) stateNext = S_DONE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (!active) begin
        phase  <= 1'b0;
        bitCnt <= '0;
      end else begin
        phase <= ~phase;
        if (phase) bitCnt <= bitEnd ? '0 : bitCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = (state == S_IDLE) && rdReq && owned;
    stb.drive   = (state == S_CMD) || (state == S_ADDR);
    stb.txShift = stb.drive && phase;
    stb.rxShift = (state == S_DATA) && phase;
    stb.respond = (state == S_DONE) || (state == S_ERR);
    stb.err     = (state == S_ERR);
  end

  assign csN  = ~active;
  assign sclk = active && phase;

endmodule

// File: rtl/sflash_mmap_dpath.sv
module sflash_mmap_dpath
  import sflash_mmap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic                    cfgSel,
  input  logic [31:0]             cfgWrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [3:0]              sdIn,
  input  seqStrobe_t              stb,
  output readShape_t              shape,
  output logic                    pinsOwned,
  output logic                    mosi,
  output logic                    rdValid,
  output logic                    rdErr,
  output logic [8*DATA_BYTES-1:0] rdData
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int TX_W   = 8 + ADDR_W;
  localparam int ADDR_BYTES_MAX = ADDR_W / 8;

  logic [7:0] readOp;
  logic [1:0] addrCode;
  logic [1:0] dummyBytes;
  logic [1:0] readType;
  logic [4:0] dummyBits;
  logic       ownBit;
  logic [TX_W-1:0]   txReg;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] word;
  logic [ADDR_W-1:0] addrAligned;
  logic [2:0]        addrBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readOp     <= 8'h03;
      addrCode   <= 2'd2;
      dummyBytes <= 2'd0;
      readType   <= 2'd0;
      dummyBits  <= 5'd0;
      ownBit     <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgSel) begin
        ownBit <= cfgWrData[0];
      end else begin
        readOp     <= cfgWrData[7:0];
        addrCode   <= cfgWrData[9:8];
        dummyBytes <= cfgWrData[11:10];
        readType   <= cfgWrData[13:12];
        dummyBits  <= cfgWrData[28:24];
      end
    end
  end

  assign addrBytes       = {1'b0, addrCode} + 3'd1;
  assign shape.addrBytes = addrBytes;
  assign shape.dummyClks = {1'b0, dummyBytes, 3'b000} + {1'b0, dummyBits};
  assign shape.quad      = (readType == 2'd3);
  assign pinsOwned       = ownBit;

  // Left-align the used address bytes so they leave the shifter first
  assign addrAligned = rdAddr << (8 * (ADDR_BYTES_MAX - int'(addrBytes)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (stb.load)
        txReg <= {readOp, addrAligned};
      else if (stb.txShift)
        txReg <= {txReg[TX_W-2:0], 1'b0};
      if (stb.rxShift)
        rxReg <= shape.quad ? {rxReg[DATA_W-5:0], sdIn}
                            : {rxReg[DATA_W-2:0], sdIn[1]};
    end
  end

  assign mosi = stb.drive & txReg[TX_W-1];

  // First received byte sits at the top of rxReg; place it in the low byte
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_swap
    assign word[8*b +: 8] = rxReg[8*(DATA_BYTES-1-b) +: 8];
  end

  assign rdValid = stb.respond;
  assign rdErr   = stb.err;
  assign rdData  = (stb.respond && !stb.err) ? word : '0;

endmodule

// File: rtl/sflash_mmap_reader.sv
module sflash_mmap_reader
  import sflash_mmap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic                    cfgSel,
  input  logic [31:0]             cfgWrData,
  input  logic                    rdReq,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    rdValid,
  output logic                    rdErr,
  output logic [8*DATA_BYTES-1:0] rdData,
  output logic                    pinsOwned,
  output logic                    csN,
  output logic                    sclk,
  output logic                    mosi,
  input  logic [3:0]              sdIn
);

  seqStrobe_t stb;
  readShape_t shape;

  sflash_mmap_ctrl #(.DATA_BYTES(DATA_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .owned(pinsOwned),
    .shape(shape), .stb(stb), .csN(csN), .sclk(sclk)
  );

  sflash_mmap_dpath #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .rdAddr(rdAddr), .sdIn(sdIn), .stb(stb),
    .shape(shape), .pinsOwned(pinsOwned), .mosi(mosi), .rdValid(rdValid),
    .rdErr(rdErr), .rdData(rdData)
  );

endmodule

// File: rtl/sflash_mmap_checker.sv
module sflash_mmap_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic rdValid,
  input logic rdErr,
  input logic pinsOwned
);

  AST_CS_HELD_UNOWNED: assert property (@(posedge clk) disable iff (!rstN)
    (!pinsOwned && csN) |=> csN);  // R6

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdValid);  // R7

  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (csN && $past(csN)));  // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);  // R8

  AST_CS_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (rdValid && !rdErr));  // R8

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R9

  AST_SCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |=> !sclk);  // R9

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));  // R9

endmodule

bind sflash_mmap_reader sflash_mmap_checker chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
  .rdValid(rdValid), .rdErr(rdErr), .pinsOwned(pinsOwned)
);

// File: tb/sflash_mmap_reader_tb.sv
`timescale 1ns/100ps
module sflash_mmap_reader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        rdReq = 1'b0;
  logic [31:0] rdAddr = '0;
  logic        rdValid, rdErr, pinsOwned, csN, sclk, mosi;
  logic [31:0] rdData;
  logic [3:0]  sdIn = 4'h0;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;  // 250 MHz

  sflash_mmap_reader dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdErr(rdErr), .rdData(rdData),
    .pinsOwned(pinsOwned), .csN(csN), .sclk(sclk), .mosi(mosi), .sdIn(sdIn)
  );

  // ---------------- flash model ----------------
  int   clkCount = 0;
  int   preClks = 16;
  bit   quadMode = 1'b0;
  logic mosiCap [0:127];
  logic [7:0] expB [0:3];

  always @(negedge csN) clkCount = 0;

  always @(posedge sclk) begin
    if (!csN) begin
      if (clkCount < 128) mosiCap[clkCount] = mosi;
      clkCount = clkCount + 1;
    end
  end

  always @(negedge sclk) begin
    #1;
    if (!csN && clkCount >= preClks) begin
      int j;
      logic [7:0] b;
      j = clkCount - preClks;
      if (quadMode) begin
        if (j < 8) begin
          b = expB[j / 2];
          sdIn = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
      end else if (j < 32) begin
        b = expB[j / 8];
        sdIn = {~b[7 - j % 8], ~b[7 - j % 8], b[7 - j % 8], ~b[7 - j % 8]};
      end
    end
  end

  // ---------------- timing monitor (R9) ----------------
  int   timingViol = 0;
  int   csLowCount = 0;
  logic prevSclk = 1'b0;
  logic prevMosi = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclk && prevSclk) timingViol++;
      if (sclk && (mosi !== prevMosi)) timingViol++;
      if (csN && sclk) timingViol++;
      if (!csN) csLowCount++;
    end
    prevSclk = sclk;
    prevMosi = mosi;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkSetup(input logic [7:0] op, input logic [1:0] code,
      input logic [1:0] db, input logic [1:0] rt, input logic [4:0] bits,
      input logic [7:0] wrOp);
    return {3'b000, bits, wrOp, 2'b00, rt, db, code, op};
  endfunction

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doRead(input string tag, input logic [31:0] addr, input logic [7:0] op,
      input int nAddr, input int dummy, input bit quad);
    logic [31:0] expWord;
    logic [7:0]  gotOp;
    logic [31:0] gotAddr;
    logic [31:0] expAddr;
    int waitCnt;
    for (int k = 0; k < 4; k++) expB[k] = addr[7:0] * 8'd3 + 8'(k * 17) + 8'h5A;
    expWord  = {expB[3], expB[2], expB[1], expB[0]};
    preClks  = 8 + 8 * nAddr + dummy;
    quadMode = quad;
    @(negedge clk);
    rdReq = 1'b1; rdAddr = addr;
    @(negedge clk);
    rdReq = 1'b0;
    waitCnt = 0;
    while (!rdValid && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(rdValid === 1'b1, {tag, " R8 response arrives"}, 64'(rdValid), 64'd1);
    check(rdErr === 1'b0, {tag, " R8 no error"}, 64'(rdErr), 64'd0);
    check(csN === 1'b1, {tag, " R8 cs high with valid"}, 64'(csN), 64'd1);
    check(rdData === expWord, {tag, " R5 data word"}, 64'(rdData), 64'(expWord));
    gotOp = '0;
    for (int i = 0; i < 8; i++) gotOp = {gotOp[6:0], mosiCap[i]};
    check(gotOp === op, {tag, " R1 opcode"}, 64'(gotOp), 64'(op));
    gotAddr = '0;
    for (int i = 0; i < 8 * nAddr; i++) gotAddr = {gotAddr[30:0], mosiCap[8 + i]};
    expAddr = (nAddr == 4) ? addr : (addr & ((32'd1 << (8 * nAddr)) - 32'd1));
    check(gotAddr === expAddr, {tag, " R2 address bytes"}, 64'(gotAddr), 64'(expAddr));
    check(clkCount == preClks + (quad ? 8 : 32), {tag, " R3 R4 clock count"},
          64'(clkCount), 64'(preClks + (quad ? 8 : 32)));
    @(negedge clk);
    check(rdValid === 1'b0, {tag, " R8 valid one cycle"}, 64'(rdValid), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(csN === 1'b1, "R10 reset csN", 64'(csN), 64'd1);
    check(sclk === 1'b0, "R10 reset sclk", 64'(sclk), 64'd0);
    check(pinsOwned === 1'b0, "R10 reset pinsOwned", 64'(pinsOwned), 64'd0);
    check(rdValid === 1'b0, "R10 reset rdValid", 64'(rdValid), 64'd0);
  endtask

  task automatic t_errorUnowned(input string tag);
    int csBefore;
    csBefore = csLowCount;
    @(negedge clk);
    rdReq = 1'b1; rdAddr = 32'h0000_1000;
    @(negedge clk);
    rdReq = 1'b0;
    check(rdValid === 1'b1 && rdErr === 1'b1, {tag, " R7 error response next cycle"},
          64'({rdValid, rdErr}), 64'h3);
    repeat (4) @(negedge clk);
    check(csLowCount == csBefore, {tag, " R7 no chip select"}, 64'(csLowCount - csBefore), 64'd0);
    check(rdValid === 1'b0, {tag, " R7 response is one cycle"}, 64'(rdValid), 64'd0);
  endtask

  task automatic t_defaultSetup();
    cfgWrite(1'b1, 32'h0000_0001);
    check(pinsOwned === 1'b1, "R6 switch set gives ownership", 64'(pinsOwned), 64'd1);
    doRead("default R10", 32'h0012_3456, 8'h03, 3, 0, 1'b0);
  endtask

  task automatic t_quadRead();
    // write opcode field filled with a nonzero value: must not matter (R3)
    cfgWrite(1'b0, mkSetup(8'h6B, 2'd2, 2'd1, 2'd3, 5'd0, 8'h02));
    doRead("quad R4", 32'h00AB_CDEF, 8'h6B, 3, 8, 1'b1);
  endtask

  task automatic t_fourByteExtraBits();
    cfgWrite(1'b0, mkSetup(8'h0C, 2'd3, 2'd2, 2'd0, 5'd5, 8'hFF));
    doRead("addr4 R2 R3", 32'h89AB_CDEF, 8'h0C, 4, 21, 1'b0);
  endtask

  task automatic t_oneByteQuadBits();
    cfgWrite(1'b0, mkSetup(8'hEB, 2'd0, 2'd0, 2'd3, 5'd6, 8'h00));
    doRead("addr1 R2 R3 R4", 32'h0000_007E, 8'hEB, 1, 6, 1'b1);
  endtask

  task automatic t_singleNonQuadType();
    // read type 1 is not quad: single line on sdIn[1]
    cfgWrite(1'b0, mkSetup(8'h3B, 2'd1, 2'd0, 2'd1, 5'd0, 8'h00));
    doRead("type1 R4", 32'h0000_C35A, 8'h3B, 2, 0, 1'b0);
  endtask

  task automatic t_timing();
    check(timingViol == 0, "R9 serial clock timing", 64'(timingViol), 64'd0);
  endtask

  task automatic t_switchBack();
    cfgWrite(1'b1, 32'h0000_0000);
    check(pinsOwned === 1'b0, "R6 switch clear releases pins", 64'(pinsOwned), 64'd0);
    t_errorUnowned("after release R6");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_errorUnowned("unowned R7");
    t_defaultSetup();
    t_quadRead();
    t_fourByteExtraBits();
    t_oneByteQuadBits();
    t_singleNonQuadType();
    t_timing();
    t_switchBack();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule